// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block performs automatic RTS/CTS handshaking for one UART channel. On the transmit side it produces a permit signal. The serializer samples this signal before it starts each new character. While automatic CTS handling is enabled and the remote end holds CTS high, the permit is withdrawn. A character that is already being shifted out is never interrupted: the permit only changes at a character boundary. The CTS pin is asynchronous to the local clock, so it passes through a two-flop synchronizer before it is used.

On the receive side the block watches the receive FIFO fill count against a trigger threshold. Two select bits choose the threshold from an ordered set of four values. The set is derived from the FIFO depth and comes to 8, 16, 56 and 60 for a 64-entry FIFO. When the fill count reaches the chosen threshold, the block raises an interrupt. It drives RTS high to stop the sender only when the fill count reaches the next threshold up. It lets RTS fall again only after the FIFO has drained below the next threshold down. This gap gives hysteresis. With automatic RTS switched off, the pin follows the modem-control RTS bit.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rts_pin` is 1, `tx_permit` is 1 and `rx_trig_irq` is 0, and both CTS synchronizer stages hold 0.
- R2: `trig_sel` values 0, 1, 2 and 3 select the thresholds 8, 16, 56 and 60. With `auto_rts_en` = 1, `rx_trig_irq` is 1 one clock after `rx_fill` is at or above the selected threshold. It is 0 one clock after `rx_fill` is below the threshold, and it is 0 while `auto_rts_en` = 0.
- R3: With `auto_rts_en` = 1, `rts_pin` becomes 1 one clock after `rx_fill` reaches the stop level. The stop level is 16, 56, 60 or 64 for `trig_sel` 0, 1, 2 or 3; the last value is the FIFO depth.
- R4: With `auto_rts_en` = 1, `rts_pin` returns to 0 one clock after `rx_fill` drops below the resume level. The resume level is 8, 16 or 56 for `trig_sel` 1, 2 or 3. For `trig_sel` 0 the pin returns to 0 only when the FIFO is empty. Between the two levels, `rts_pin` holds its value.
- R5: With `auto_rts_en` = 0, `rts_pin` equals the inverse of `mcr_rts` one clock later, and `rx_fill` has no effect on it.
- R6: With `auto_cts_en` = 1 and `tx_char_active` = 0, `tx_permit` falls on the third rising edge after `cts_pin` rises and not earlier. It rises on the third rising edge after `cts_pin` falls.
- R7: While `tx_char_active` = 1, `tx_permit` keeps its value. A pending change takes effect on the first edge at which `tx_char_active` is 0.
- R8: With `auto_cts_en` = 0, `tx_permit` is 1 one clock after any cycle with `tx_char_active` = 0, whatever the level of `cts_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_pin | input | 1 | Remote clear-to-send, 1 = stop sending (asynchronous) |
| auto_cts_en | input | 1 | Enables transmit gating by CTS |
| auto_rts_en | input | 1 | Enables fill-driven RTS and the trigger interrupt |
| mcr_rts | input | 1 | Modem-control RTS bit, 1 drives the pin low |
| trig_sel | input | 2 | Threshold select, 0..3 |
| rx_fill | input | 7 | Receive FIFO fill count, 0..64 |
| tx_char_active | input | 1 | Serializer is shifting a character |
| rts_pin | output | 1 | Request-to-send pin, 1 = stop the sender |
| tx_permit | output | 1 | Serializer may start a new character |
| rx_trig_irq | output | 1 | Receive trigger reached |

## Verification
Two functions can fall in the same cycle. The receive threshold crossing, with its interrupt and RTS stop, can coincide with a CTS edge on the transmit path. Within the receive side, a single fill jump can cross both the trigger threshold and the stop level. The bench provokes both cases from one input change. It jumps the fill from empty past the stop level in the same cycle that CTS rises, and later returns both together. It then judges each output at its own latency: one clock for the interrupt and RTS, three clocks for the permit. Each output must move on exactly its own clock edge, unaffected by activity on the other path.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Ordered threshold set, derived from the FIFO depth (8,16,56,60 for 64).
  function automatic int fc_level(input int depth, input logic [1:0] sel);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth - 8;
      default: return depth - 4;
    endcase
  endfunction

  // Stop level: one threshold above the selected one, capped at depth.
  function automatic int fc_up(input int depth, input logic [1:0] sel);
    if (sel == 2'd3) return depth;
    return fc_level(depth, sel + 2'd1);
  endfunction

  // Resume level: one threshold below the selected one, zero at the bottom.
  function automatic int fc_down(input int depth, input logic [1:0] sel);
    if (sel == 2'd0) return 0;
    return fc_level(depth, sel - 2'd1);
  endfunction

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], async_in};
  end

  assign sync_out = sr_q[STAGES-1];
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_sync,
  input  logic auto_cts_en,
  input  logic char_active,
  output logic permit,
  output logic pause_ev
);
  // Pause requested and allowed to take effect now (character boundary).
  assign pause_ev = !char_active && auto_cts_en && cts_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            permit <= 1'b1;
    else if (!char_active) permit <= !(auto_cts_en && cts_sync);
  end
endmodule

// File: rtl/fc_rx_level.sv
module fc_rx_level
  import fc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [1:0]       sel,
  input  logic             auto_en,
  input  logic             mcr_rts,
  output logic             rts_pin,
  output logic             trig_irq,
  output logic             lvl_hit,
  output logic             set_ev,
  output logic             rel_ev,
  output logic             hold_q
);
  int  fill_i;
  logic hold_nxt;

  assign fill_i  = int'(fill);
  assign lvl_hit = fill_i >= fc_level(DEPTH, sel);
  assign set_ev  = fill_i >= fc_up(DEPTH, sel);
  assign rel_ev  = (fill_i < fc_down(DEPTH, sel)) || (fill == '0);
  assign hold_nxt = auto_en && (set_ev || (hold_q && !rel_ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      rts_pin  <= 1'b1;
      trig_irq <= 1'b0;
    end else begin
      hold_q   <= hold_nxt;
      rts_pin  <= auto_en ? hold_nxt : !mcr_rts;
      trig_irq <= auto_en && lvl_hit;
    end
  end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_pin,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             mcr_rts,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic             tx_char_active,
  output logic             rts_pin,
  output logic             tx_permit,
  output logic             rx_trig_irq
);
  logic cts_s;
  logic tx_pause_ev;
  logic rx_lvl_hit;
  logic rts_set_ev;
  logic rts_rel_ev;
  logic rts_hold;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_pin), .sync_out(cts_s)
  );

  fc_tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .cts_sync(cts_s), .auto_cts_en(auto_cts_en),
    .char_active(tx_char_active), .permit(tx_permit), .pause_ev(tx_pause_ev)
  );

  fc_rx_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fill(rx_fill), .sel(trig_sel),
    .auto_en(auto_rts_en), .mcr_rts(mcr_rts), .rts_pin(rts_pin),
    .trig_irq(rx_trig_irq), .lvl_hit(rx_lvl_hit), .set_ev(rts_set_ev),
    .rel_ev(rts_rel_ev), .hold_q(rts_hold)
  );
endmodule

// File: rtl/fc_chk.sv
module fc_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_cts_en,
  input logic auto_rts_en,
  input logic mcr_rts,
  input logic tx_char_active,
  input logic rts_pin,
  input logic tx_permit,
  input logic rx_trig_irq,
  input logic rx_lvl_hit,
  input logic rts_set_ev,
  input logic rts_rel_ev,
  input logic rts_hold,
  input logic tx_pause_ev
);
  // R2
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && rx_lvl_hit |=> rx_trig_irq);
  // R2
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lvl_hit |=> !rx_trig_irq);
  // R3
  rts_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && rts_set_ev |=> rts_pin);
  // R4
  rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && rts_rel_ev |=> !rts_pin);
  // R4
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en && rts_hold && !rts_rel_ev |=> rts_hold && rts_pin);
  // R5
  rts_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> rts_pin == !$past(mcr_rts));
  // R7
  permit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_char_active |=> $stable(tx_permit));
  // R6
  permit_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pause_ev |=> !tx_permit);
  // R8
  permit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en && !tx_char_active |=> tx_permit);
endmodule

bind uart_flow_ctrl fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
  .auto_rts_en(auto_rts_en), .mcr_rts(mcr_rts),
  .tx_char_active(tx_char_active), .rts_pin(rts_pin),
  .tx_permit(tx_permit), .rx_trig_irq(rx_trig_irq),
  .rx_lvl_hit(rx_lvl_hit), .rts_set_ev(rts_set_ev),
  .rts_rel_ev(rts_rel_ev), .rts_hold(rts_hold), .tx_pause_ev(tx_pause_ev)
);

// File: tb/sim_uart_flow_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_pin = 1'b0;
  logic       auto_cts_en = 1'b0;
  logic       auto_rts_en = 1'b0;
  logic       mcr_rts = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [6:0] rx_fill = 7'd0;
  logic       tx_char_active = 1'b0;
  logic       rts_pin, tx_permit, rx_trig_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_flow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cts_pin(cts_pin), .auto_cts_en(auto_cts_en),
    .auto_rts_en(auto_rts_en), .mcr_rts(mcr_rts), .trig_sel(trig_sel),
    .rx_fill(rx_fill), .tx_char_active(tx_char_active), .rts_pin(rts_pin),
    .tx_permit(tx_permit), .rx_trig_irq(rx_trig_irq)
  );

  // Thresholds restated from the requirements.
  function automatic int thr(input int s);
    int t[4] = '{8, 16, 56, 60};
    return t[s];
  endfunction
  function automatic int stop_lvl(input int s);
    return (s == 3) ? 64 : thr(s + 1);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Advance n rising edges and settle at the following falling edge.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rts_pin", rts_pin, 1'b1);
    chk("R1 tx_permit", tx_permit, 1'b1);
    chk("R1 rx_trig_irq", rx_trig_irq, 1'b0);
  endtask

  task automatic t_manual_rts();
    auto_rts_en = 0; rx_fill = 7'd64; mcr_rts = 1; step(1);
    chk("R5 mcr=1 full fifo", rts_pin, 1'b0);
    chk("R2 irq off when auto rts off", rx_trig_irq, 1'b0);
    mcr_rts = 0; step(1);
    chk("R5 mcr=0", rts_pin, 1'b1);
    rx_fill = 0; step(1);
  endtask

  task automatic t_levels();
    auto_rts_en = 1;
    for (int s = 0; s < 4; s++) begin
      int lo;
      lo = (s == 0) ? 1 : thr(s - 1);
      trig_sel = 2'(s); rx_fill = 0; step(1);
      chk("R4 empty", rts_pin, 1'b0);
      rx_fill = 7'(thr(s) - 1); step(1);
      chk("R2 below threshold", rx_trig_irq, 1'b0);
      rx_fill = 7'(thr(s)); step(1);
      chk("R2 at threshold", rx_trig_irq, 1'b1);
      chk("R3 at threshold no stop", rts_pin, 1'b0);
      rx_fill = 7'(stop_lvl(s) - 1); step(1);
      chk("R3 below stop", rts_pin, 1'b0);
      rx_fill = 7'(stop_lvl(s)); step(1);
      chk("R3 at stop", rts_pin, 1'b1);
      rx_fill = 7'(lo); step(1);
      chk("R4 hold at resume level", rts_pin, 1'b1);
      chk("R2 irq cleared", rx_trig_irq, 1'b0);
      rx_fill = 7'(lo - 1); step(1);
      chk("R4 released", rts_pin, 1'b0);
    end
    rx_fill = 0; auto_rts_en = 0; step(1);
  endtask

  task automatic t_cts_sync();
    auto_cts_en = 1; tx_char_active = 0; cts_pin = 1; step(2);
    chk("R6 not before third edge", tx_permit, 1'b1);
    step(1);
    chk("R6 stopped on third edge", tx_permit, 1'b0);
    cts_pin = 0; step(2);
    chk("R6 still stopped", tx_permit, 1'b0);
    step(1);
    chk("R6 resumed on third edge", tx_permit, 1'b1);
  endtask

  task automatic t_boundary();
    auto_cts_en = 1; tx_char_active = 1; cts_pin = 1; step(5);
    chk("R7 no cut mid-character", tx_permit, 1'b1);
    tx_char_active = 0; step(1);
    chk("R7 pause at boundary", tx_permit, 1'b0);
    tx_char_active = 1; cts_pin = 0; step(5);
    chk("R7 held while busy", tx_permit, 1'b0);
    tx_char_active = 0; step(1);
    chk("R7 resume at boundary", tx_permit, 1'b1);
  endtask

  task automatic t_cts_off();
    auto_cts_en = 0; cts_pin = 1; step(4);
    chk("R8 cts ignored", tx_permit, 1'b1);
    cts_pin = 0; step(3);
  endtask

  task automatic t_concurrent();
    auto_cts_en = 1; auto_rts_en = 1; trig_sel = 2'd1; rx_fill = 0; cts_pin = 0;
    step(4);
    cts_pin = 1; rx_fill = 7'd60; step(1);
    chk("R2 irq with cts edge", rx_trig_irq, 1'b1);
    chk("R3 rts with cts edge", rts_pin, 1'b1);
    chk("R6 permit not yet", tx_permit, 1'b1);
    step(2);
    chk("R6 permit stopped", tx_permit, 1'b0);
    cts_pin = 0; rx_fill = 0; step(1);
    chk("R4 release with cts edge", rts_pin, 1'b0);
    chk("R2 irq cleared with cts edge", rx_trig_irq, 1'b0);
    chk("R6 permit still stopped", tx_permit, 1'b0);
    step(2);
    chk("R6 permit back", tx_permit, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: got hang expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    step(3);
    t_reset();
    rst_n = 1; step(1);
    t_reset();
    t_manual_rts();
    t_levels();
    t_cts_sync();
    t_boundary();
    t_cts_off();
    t_concurrent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule